// File: doc/BRIEF.md
# Dual-Width ROM Read Port

This block is the read front end of a read-only array stored as 16-bit words. A host reads it either as whole 16-bit words or as single bytes. Two active-low controls gate the output. Chip enable selects the device and puts it into standby when released. Output enable decides whether an enabled device actually drives its data lanes.

One pin changes role with the width setting. In word mode it is data bit 15, an output. In byte mode it is an extra low address bit, an input, that picks which half of the addressed word appears on the low byte lane.

A separate identification mode returns a fixed two-byte code, with address bit 0 choosing which byte is returned. This mode is entered through a strobe input instead of a raised voltage on an address pin.

All results are registered: the port samples its inputs on a rising clock edge and presents data together with per-lane drive enables after that edge. The array contents are a computed pattern, so a ROM image of any size can replace them without touching the port logic.

Top module: `dwrom_port`

## Requirements
- R1: While the synchronous reset `rst_n` is low, the next clock edge sets `standby` to 1, all three lane enables to 0, and all data outputs to 0.
- R2: Every output is a register. The outputs seen after a rising edge reflect the inputs sampled at that edge, and they do not change before the following edge.
- R3: With `chip_en_n` high, `standby` is 1 and `lo_oe`, `mid_oe` and `d15_oe` are all 0, whatever `out_en_n` is.
- R4: With `chip_en_n` low and `out_en_n` high, `standby` is 0 and all three lane enables are 0.
- R5: A word read (`chip_en_n` and `out_en_n` low, `wide_sel` high, `sig_mode` low) drives bits 7..0 of the word on `data_lo`, bits 14..8 on `data_mid` and bit 15 on `d15_out`, with all three enables high. The `byte_sel_in` input has no effect in this mode.
- R6: A byte read (`wide_sel` low) puts bits 7..0 of the word on `data_lo` when `byte_sel_in` is 0, and bits 15..8 when it is 1. Only `lo_oe` is high; `mid_oe` and `d15_oe` are 0.
- R7: In identification mode (`sig_mode` high, `chip_en_n` and `out_en_n` low), `data_lo` is 0x20 when `addr[0]` is 0 and 0xB1 when it is 1. `data_mid` and `d15_out` are 0. The lane enables follow `wide_sel` as in R5 and R6, and `addr[19:1]` and `byte_sel_in` have no effect.
- R8: Any lane whose enable is 0 carries all-zero data, so no stale word is left on an undriven lane.
- R9: The word at address `a` has low byte `idx ^ 0xC3` and high byte `(3*idx + 0x5A) mod 256`, where `idx = a[5:0]` for the default 64-word array. The address bits above the index are ignored, so higher addresses alias onto the array.
- R10: A change of `wide_sel` between two consecutive enabled cycles changes the lane enables and data layout on the very next output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en_n | input | 1 | Device select, active low; high means standby |
| out_en_n | input | 1 | Output gate, active low |
| wide_sel | input | 1 | 1 = 16-bit word reads, 0 = byte reads |
| sig_mode | input | 1 | Selects the identification-code read |
| addr | input | 20 | Word address |
| byte_sel_in | input | 1 | Shared pin acting as the byte-half address bit in byte mode |
| data_lo | output | 8 | Data lane 7..0 |
| lo_oe | output | 1 | Drive enable for data_lo |
| data_mid | output | 7 | Data lane 14..8 |
| mid_oe | output | 1 | Drive enable for data_mid |
| d15_out | output | 1 | Data bit 15, the shared pin's output role in word mode |
| d15_oe | output | 1 | Drive enable for d15_out |
| standby | output | 1 | High while the device is deselected |

## Verification
Random vectors cover every combination of the two enables, the width select, the identification strobe and the byte-half input over the full 20-bit address. This separates the standby, disabled, word, byte and code paths and exposes aliasing of the high address bits.

Directed vectors target the following cases:
- the first and last array words, and an aliased address;
- both byte halves of one word;
- `byte_sel_in` toggled during a word read;
- both identification codes under each width setting;
- back-to-back width switches, which would show stale upper-lane data;
- a hold check between edges, which tells a registered output apart from a combinational one.

// File: rtl/dwrom_pkg.sv
// Package: shared constants, mode encoding, output bundle and the computed
// array contents for the dual-width ROM read port.
// Assumes a 16-bit word split into an 8-bit low lane, a 7-bit middle lane
// and a single top bit.
package dwrom_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int MID_W  = WORD_W - BYTE_W - 1;

    localparam logic [BYTE_W-1:0] ID_CODE_0 = 8'h20;
    localparam logic [BYTE_W-1:0] ID_CODE_1 = 8'hB1;

    typedef enum logic [2:0] {
        PM_STANDBY  = 3'd0,
        PM_OUT_OFF  = 3'd1,
        PM_WORD     = 3'd2,
        PM_BYTE     = 3'd3,
        PM_ID_WORD  = 3'd4,
        PM_ID_BYTE  = 3'd5
    } port_mode_e;

    typedef struct packed {
        logic              standby;
        logic              oe_top;
        logic              oe_mid;
        logic              oe_lo;
        logic [WORD_W-1:0] data;
    } out_bundle_t;

    // Content of array entry idx: low byte idx^0xC3, high byte 3*idx+0x5A.
    function automatic logic [WORD_W-1:0] rom_word(input int unsigned idx);
        int unsigned hi_full;
        int unsigned lo_full;
        hi_full = (idx * 3 + 32'h5A) & 32'hFF;
        lo_full = (idx ^ 32'hC3) & 32'hFF;
        return {hi_full[BYTE_W-1:0], lo_full[BYTE_W-1:0]};
    endfunction

endpackage

// File: rtl/dwrom_mode_dec.sv
// Mode decoder: turns the two active-low controls, the width select and the
// identification strobe into one port mode.
// Assumes chip enable dominates output enable, which dominates the rest.
module dwrom_mode_dec
    import dwrom_pkg::*;
(
    input  logic       chip_en_n,
    input  logic       out_en_n,
    input  logic       wide_sel,
    input  logic       sig_mode,
    output port_mode_e mode
);

    // Priority decode of the control pins.
    always_comb begin
        if (chip_en_n) begin
            mode = PM_STANDBY;
        end else if (out_en_n) begin
            mode = PM_OUT_OFF;
        end else if (sig_mode) begin
            mode = wide_sel ? PM_ID_WORD : PM_ID_BYTE;
        end else begin
            mode = wide_sel ? PM_WORD : PM_BYTE;
        end
    end

endmodule

// File: rtl/dwrom_array.sv
// Read-only word array: 2**DEPTH_LOG2 entries whose contents come from the
// package function, with a combinational read by index.
// Assumes the index is already cut down to DEPTH_LOG2 bits.
module dwrom_array
    import dwrom_pkg::*;
#(
    parameter int DEPTH_LOG2 = 6
) (
    input  logic [DEPTH_LOG2-1:0] idx,
    output logic [WORD_W-1:0]     word
);

    localparam int DEPTH = 1 << DEPTH_LOG2;

    logic [WORD_W-1:0] rom_mem [DEPTH];

    // One constant entry per location, generated from the content function.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign rom_mem[g] = rom_word(g);
    end

    // Combinational read of the selected entry.
    always_comb begin
        word = rom_mem[idx];
    end

endmodule

// File: rtl/dwrom_lane_mux.sv
// Lane mux: from the mode, the addressed word, the byte-half select and the
// identification address bit, builds the next output bundle.
// Assumes lanes that are not enabled must carry zero.
module dwrom_lane_mux
    import dwrom_pkg::*;
(
    input  port_mode_e        mode,
    input  logic [WORD_W-1:0] word,
    input  logic              byte_half,
    input  logic              id_sel,
    output out_bundle_t       nxt
);

    logic [BYTE_W-1:0] id_byte;
    logic [BYTE_W-1:0] half_byte;

    // Pick the identification byte and the addressed half of the word.
    always_comb begin
        id_byte   = id_sel ? ID_CODE_1 : ID_CODE_0;
        half_byte = byte_half ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
    end

    // Lane enables and data layout for each mode; idle lanes are zeroed.
    always_comb begin
        nxt = '0;
        unique case (mode)
            PM_STANDBY: begin
                nxt.standby = 1'b1;
            end
            PM_OUT_OFF: begin
                nxt.standby = 1'b0;
            end
            PM_WORD: begin
                nxt.oe_lo  = 1'b1;
                nxt.oe_mid = 1'b1;
                nxt.oe_top = 1'b1;
                nxt.data   = word;
            end
            PM_BYTE: begin
                nxt.oe_lo  = 1'b1;
                nxt.data   = {{BYTE_W{1'b0}}, half_byte};
            end
            PM_ID_WORD: begin
                nxt.oe_lo  = 1'b1;
                nxt.oe_mid = 1'b1;
                nxt.oe_top = 1'b1;
                nxt.data   = {{BYTE_W{1'b0}}, id_byte};
            end
            PM_ID_BYTE: begin
                nxt.oe_lo  = 1'b1;
                nxt.data   = {{BYTE_W{1'b0}}, id_byte};
            end
            default: begin
                nxt.standby = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dwrom_port.sv
// Dual-width ROM read port top: decodes the mode, reads the array, builds
// the lane bundle and registers it, so outputs follow the sampled inputs
// by one clock. Assumes ADDR_W > DEPTH_LOG2 and that higher address bits
// alias onto the array.
module dwrom_port
    import dwrom_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DEPTH_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en_n,
    input  logic              out_en_n,
    input  logic              wide_sel,
    input  logic              sig_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_sel_in,
    output logic [BYTE_W-1:0] data_lo,
    output logic              lo_oe,
    output logic [MID_W-1:0]  data_mid,
    output logic              mid_oe,
    output logic              d15_out,
    output logic              d15_oe,
    output logic              standby
);

    port_mode_e        mode;
    logic [WORD_W-1:0] word;
    out_bundle_t       nxt;
    out_bundle_t       out_q;
    logic              unused_addr_hi;

    assign unused_addr_hi = ^addr[ADDR_W-1:DEPTH_LOG2];

    dwrom_mode_dec u_dec (
        .chip_en_n (chip_en_n),
        .out_en_n  (out_en_n),
        .wide_sel  (wide_sel),
        .sig_mode  (sig_mode),
        .mode      (mode)
    );

    dwrom_array #(.DEPTH_LOG2(DEPTH_LOG2)) u_array (
        .idx  (addr[DEPTH_LOG2-1:0]),
        .word (word)
    );

    dwrom_lane_mux u_mux (
        .mode      (mode),
        .word      (word),
        .byte_half (byte_sel_in),
        .id_sel    (addr[0]),
        .nxt       (nxt)
    );

    // Output register: reset to standby with all lanes off and zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q         <= '0;
            out_q.standby <= 1'b1;
        end else begin
            out_q <= nxt;
        end
    end

    // Split the registered bundle onto the lane ports.
    always_comb begin
        data_lo  = out_q.data[BYTE_W-1:0];
        data_mid = out_q.data[WORD_W-2:BYTE_W];
        d15_out  = out_q.data[WORD_W-1];
        lo_oe    = out_q.oe_lo;
        mid_oe   = out_q.oe_mid;
        d15_oe   = out_q.oe_top;
        standby  = out_q.standby;
    end

endmodule

// File: rtl/dwrom_port_chk.sv
// Checker for the dual-width ROM read port: relates the sampled controls to
// the registered lane enables and data. Bound to every dwrom_port instance.
module dwrom_port_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en_n,
    input logic              out_en_n,
    input logic              wide_sel,
    input logic              sig_mode,
    input logic [ADDR_W-1:0] addr,
    input logic              byte_sel_in,
    input logic [7:0]        data_lo,
    input logic              lo_oe,
    input logic [6:0]        data_mid,
    input logic              mid_oe,
    input logic              d15_out,
    input logic              d15_oe,
    input logic              standby
);

    // R3: deselected device is in standby with every lane off.
    a_r3_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(chip_en_n)) |-> (standby && !lo_oe && !mid_oe && !d15_oe));

    // R4: output enable released leaves the device awake but undriven.
    a_r4_out_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!chip_en_n && out_en_n)) |-> (!standby && !lo_oe && !mid_oe && !d15_oe));

    // R5: an enabled word-width access drives all three lanes.
    a_r5_word_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!chip_en_n && !out_en_n && wide_sel)) |-> (lo_oe && mid_oe && d15_oe));

    // R6: an enabled byte-width access drives only the low lane.
    a_r6_byte_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!chip_en_n && !out_en_n && !wide_sel)) |-> (lo_oe && !mid_oe && !d15_oe));

    // R7: identification reads return one of the two codes with a zero top half.
    a_r7_id_code: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!chip_en_n && !out_en_n && sig_mode))
        |-> (data_mid == 7'd0 && !d15_out
             && data_lo == ($past(addr[0]) ? 8'hB1 : 8'h20)));

    // R8: an undriven lane carries zero data.
    a_r8_idle_lo_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_oe |-> (data_lo == 8'd0));
    a_r8_idle_mid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mid_oe |-> (data_mid == 7'd0));
    a_r8_idle_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !d15_oe |-> !d15_out);

    // R3: standby and any lane enable never coincide.
    a_r3_standby_excl: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !(lo_oe || mid_oe || d15_oe));

    logic unused_chk;
    assign unused_chk = ^{addr[ADDR_W-1:1], byte_sel_in};

endmodule

bind dwrom_port dwrom_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_en_n   (chip_en_n),
    .out_en_n    (out_en_n),
    .wide_sel    (wide_sel),
    .sig_mode    (sig_mode),
    .addr        (addr),
    .byte_sel_in (byte_sel_in),
    .data_lo     (data_lo),
    .lo_oe       (lo_oe),
    .data_mid    (data_mid),
    .mid_oe      (mid_oe),
    .d15_out     (d15_out),
    .d15_oe      (d15_oe),
    .standby     (standby)
);

// File: tb/dwrom_port_test.sv
// Bench for dwrom_port: directed corner cases followed by seeded random
// vectors, each compared with a model built from the requirements.
module dwrom_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_en_n = 1'b1;
    logic        out_en_n = 1'b1;
    logic        wide_sel = 1'b1;
    logic        sig_mode = 1'b0;
    logic [19:0] addr = '0;
    logic        byte_sel_in = 1'b0;
    logic [7:0]  data_lo;
    logic        lo_oe;
    logic [6:0]  data_mid;
    logic        mid_oe;
    logic        d15_out;
    logic        d15_oe;
    logic        standby;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dwrom_port uut (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
        .wide_sel(wide_sel), .sig_mode(sig_mode), .addr(addr),
        .byte_sel_in(byte_sel_in), .data_lo(data_lo), .lo_oe(lo_oe),
        .data_mid(data_mid), .mid_oe(mid_oe), .d15_out(d15_out),
        .d15_oe(d15_oe), .standby(standby)
    );

    // Observed outputs packed as {standby, d15_oe, mid_oe, lo_oe, d15, mid, lo}.
    function automatic logic [19:0] observed();
        return {standby, d15_oe, mid_oe, lo_oe, d15_out, data_mid, data_lo};
    endfunction

    // Array content per R9.
    function automatic logic [15:0] model_word(input logic [19:0] a);
        int unsigned i;
        int unsigned h;
        int unsigned l;
        i = a[5:0];
        h = (3 * i + 90) % 256;
        l = i ^ 195;
        return {h[7:0], l[7:0]};
    endfunction

    // Expected outputs per R3..R8.
    function automatic logic [19:0] model_out(input logic ce, input logic oe,
        input logic w, input logic s, input logic [19:0] a, input logic b);
        logic [15:0] d;
        logic [7:0]  code;
        if (ce)  return {4'b1000, 16'h0000};
        if (oe)  return {4'b0000, 16'h0000};
        code = a[0] ? 8'hB1 : 8'h20;
        if (s)   return w ? {4'b0111, 8'h00, code} : {4'b0001, 8'h00, code};
        d = model_word(a);
        if (w)   return {4'b0111, d};
        return {4'b0001, 8'h00, (b ? d[15:8] : d[7:0])};
    endfunction

    function automatic string tag_of(input logic ce, input logic oe,
        input logic w, input logic s);
        if (ce) return "R3";
        if (oe) return "R4";
        if (s)  return "R7";
        return w ? "R5/R9" : "R6/R9";
    endfunction

    task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Apply one vector, clock it in, and compare away from the edge.
    task automatic apply(input string tag, input logic ce, input logic oe,
        input logic w, input logic s, input logic [19:0] a, input logic b);
        @(negedge clk);
        chip_en_n = ce; out_en_n = oe; wide_sel = w; sig_mode = s;
        addr = a; byte_sel_in = b;
        @(posedge clk);
        @(negedge clk);
        check(tag, observed(), model_out(ce, oe, w, s, a, b));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [19:0] held;
        void'($urandom(32'h5EED_0417));
        // R1: reset state with the device otherwise selected for a word read
        chip_en_n = 1'b0; out_en_n = 1'b0; wide_sel = 1'b1; addr = 20'h00005;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", observed(), {4'b1000, 16'h0000});
        rst_n = 1'b1;

        // R5 and R9 at both ends of the array and on an aliased address
        apply("R5_first", 0, 0, 1, 0, 20'h00000, 0);
        apply("R5_last",  0, 0, 1, 0, 20'h0003F, 0);
        apply("R9_alias", 0, 0, 1, 0, 20'hABC45, 0);
        // R5: the byte-half input is ignored in word mode
        apply("R5_bsel_ignored", 0, 0, 1, 0, 20'h0003F, 1);
        // R6: both halves of one word
        apply("R6_lower", 0, 0, 0, 0, 20'h00011, 0);
        apply("R6_upper", 0, 0, 0, 0, 20'h00011, 1);
        // R3: standby regardless of output enable
        apply("R3_oe_low",  1, 0, 1, 0, 20'h00011, 0);
        apply("R3_oe_high", 1, 1, 0, 1, 20'h00011, 1);
        // R4: output disable
        apply("R4_off", 0, 1, 1, 0, 20'h00022, 0);
        // R7: both codes under both widths, with noise on other inputs
        apply("R7_code0_word", 0, 0, 1, 1, 20'h00000, 0);
        apply("R7_code1_word", 0, 0, 1, 1, 20'h00001, 1);
        apply("R7_code0_byte", 0, 0, 0, 1, 20'hFFFFE, 1);
        apply("R7_code1_byte", 0, 0, 0, 1, 20'h00001, 0);
        // R10 and R8: width switched on consecutive cycles
        apply("R10_word",  0, 0, 1, 0, 20'h0002A, 1);
        apply("R10_byte",  0, 0, 0, 0, 20'h0002A, 1);
        apply("R10_word2", 0, 0, 1, 0, 20'h0002A, 0);
        apply("R10_byte2", 0, 0, 0, 0, 20'h0002A, 0);

        // R2: outputs hold between edges when the inputs change
        held = observed();
        @(negedge clk);
        chip_en_n = 1'b0; out_en_n = 1'b0; wide_sel = 1'b1; addr = 20'h00007;
        #2;
        check("R2_hold", observed(), held);
        @(posedge clk);
        @(negedge clk);
        check("R2_update", observed(), model_out(0, 0, 1, 0, 20'h00007, 0));

        // Random vectors, weighted towards enabled reads
        for (int k = 0; k < 600; k++) begin
            logic ce;
            logic oe;
            logic w;
            logic s;
            logic b;
            logic [19:0] a;
            ce = ($urandom % 6) == 0;
            oe = ($urandom % 6) == 0;
            w  = $urandom % 2;
            s  = ($urandom % 5) == 0;
            b  = $urandom % 2;
            a  = 20'($urandom);
            apply(tag_of(ce, oe, w, s), ce, oe, w, s, a, b);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule